// File: doc/BRIEF.md
# Iterative DES-CBC Encryption Core with Serial Scan

This block encrypts 64-bit blocks with DES in cipher-block-chaining mode. It computes one round per clock. A caller presents a plaintext block and a 56-bit key, pulses `start`, and collects the ciphertext when `done` pulses. The ciphertext register also serves as the chaining value, so each new block is XORed with the previous ciphertext before encryption. Reset clears the chaining value, so the first block after reset is a plain single-block encryption.

For manufacturing test, the block-input register, the two half-block round registers and the ciphertext register form one serial scan chain of 192 cells. While `scanEn` is high, every clock moves the chain one place toward `scanOut`, and all functional updates stop. The subkey register and the round counter sit outside the chain. They keep their values across a scan burst, so an interrupted encryption resumes where it stopped.

Top module: `des_cbc_scan`

## Requirements
- R1: Reset (active-low `rstN`) clears `cipherOut` and `done` and abandons any encryption in progress; the first block started after reset is chained with an all-zero value, so its result equals the single-block DES result.
- R2: The block computes standard DES. The 56-bit `keyIn` is the 64-bit DES key with the low (parity) bit of each byte removed, the seven remaining bits of each byte concatenated most-significant byte first. Known answers: key 133457799BBCDFF1 / input 0123456789ABCDEF gives 85E813540F0AB405; key 0 / input 0 gives 8CA64DE9C1B123A7; key FFFFFFFFFFFFFFFF / input FFFFFFFFFFFFFFFF gives 7359B2163E4EDC58; key 0E329232EA6D0D73 / input 8787878787878787 gives 0.
- R3: The value encrypted is `plainIn` XOR the value held in the ciphertext register at the capture edge, including a value placed there by scan.
- R4: Timing, counting the edge that captures `start` as edge 1 and counting only edges with `scanEn` low: after edge 2 the left/right halves hold the initial permutation of the block input. After edge 3 they hold the round-1 result. On edge 18 `cipherOut` takes the new ciphertext and `done` goes high for exactly one cycle.
- R5: `start` is ignored while an encryption is in progress (from edge 1 until the edge that raises `done`) and on any edge with `scanEn` high.
- R6: With `scanEn` high, each edge shifts the chain one place. `scanOut` always shows the chain's tail. The order seen at `scanOut` is: ciphertext register bits 0..63, then right half bits 0..31, then left half bits 0..31, then block-input bits 0..63. `scanIn` enters at block-input bit 63. Bits shifted in as V[0] first through V[191] last leave the chain equal to V, with V[63:0] in the ciphertext register.
- R7: Scan edges change no functional state. The subkey register and round counter hold, `done` stays low, and an encryption interrupted by scan bursts ends with the correct ciphertext after 18 non-scan edges.
- R8: 192 scan edges with `scanOut` fed back to `scanIn` restore every chain register. `cipherOut` changes only on the edge that raises `done` or on a scan edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin encrypting `plainIn` under `keyIn` |
| plainIn | input | 64 | Plaintext block |
| keyIn | input | 56 | DES key without parity bits |
| cipherOut | output | 64 | Ciphertext register (also the chaining value) |
| done | output | 1 | One-cycle pulse when a new ciphertext is in `cipherOut` |
| scanEn | input | 1 | Shift the scan chain instead of normal operation |
| scanIn | input | 1 | Serial scan data into the chain head |
| scanOut | output | 1 | Serial scan data from the chain tail |

## Verification
DES spreads any wrong bit in a half-block, subkey or round count across the whole ciphertext. A fault inside the round loop therefore shows as a wholly wrong `cipherOut` at the `done` pulse, 18 functional edges after start. Because of chaining, it also corrupts every later block until reset. Scan gives a faster view: shifting out after edge 2 or edge 3 shows the initial-permutation and round-1 halves directly, so a permutation or round-function defect can be isolated one round at a time. A defect in the scan path itself shows as a broken loopback or a misplaced ciphertext bit within 192 edges.

// File: rtl/des_pkg.sv
`timescale 1ns/1ps
package des_pkg;

  localparam int BLOCK_W  = 64;
  localparam int HALF_W   = BLOCK_W / 2;
  localparam int KEY_W    = 56;
  localparam int SUBKEY_W = 48;
  localparam int ROUNDS   = 16;
  localparam int RIDX_W   = $clog2(ROUNDS);
  localparam int CHAIN_W  = 2 * BLOCK_W + 2 * HALF_W;
  localparam int NUM_SBOX = SUBKEY_W / 6;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} ctrlState_e;

  typedef struct packed {
    logic loadIn;
    logic loadLR;
    logic doRound;
    logic lastRound;
    logic scanShift;
  } ctrlStrobe_t;

  // substitution boxes: nibble n (MSB first) is the entry at row*16+col
  localparam logic [255:0] SBOX_TAB [NUM_SBOX] = '{
    256'he4d12fb83a6c5907_0f74e2d1a6cb9538_41e8d62bfc973a50_fc8249175b3ea06d,
    256'hf18e6b34972dc05a_3d47f28ec01a69b5_0e7ba4d158c6932f_d8a13f42b67c05e9,
    256'ha09e63f51dc7b428_d709346a285ecbf1_d6498f30b12c5ae7_1ad069874fe3b52c,
    256'h7de3069a1285bc4f_d8b56f03472c1ae9_a690cb7df13e5284_3f06a1d8945bc72e,
    256'h2c417ab6853fd0e9_eb2c47d150fa3986_421bad78f9c5630e_b8c71e2d6f09a453,
    256'hc1af92680d34e75b_af427c9561de0b38_9ef528c3704a1db6_432c95fabe17608d,
    256'h4b2ef08d3c975a61_d0b7491ae35c2f86_14bdc37eaf680592_6bd814a7950fe23c,
    256'hd2846fb1a93e50c7_1fd8a374c56b0e92_7b419ce206adf358_21e74a8dfc90356b
  };

  localparam logic [6:0] P_TAB [HALF_W] = '{
    7'd16, 7'd7,  7'd20, 7'd21, 7'd29, 7'd12, 7'd28, 7'd17,
    7'd1,  7'd15, 7'd23, 7'd26, 7'd5,  7'd18, 7'd31, 7'd10,
    7'd2,  7'd8,  7'd24, 7'd14, 7'd32, 7'd27, 7'd3,  7'd9,
    7'd19, 7'd13, 7'd30, 7'd6,  7'd22, 7'd11, 7'd4,  7'd25
  };

  localparam logic [6:0] PC1_TAB [KEY_W] = '{
    7'd57, 7'd49, 7'd41, 7'd33, 7'd25, 7'd17, 7'd9,  7'd1,
    7'd58, 7'd50, 7'd42, 7'd34, 7'd26, 7'd18, 7'd10, 7'd2,
    7'd59, 7'd51, 7'd43, 7'd35, 7'd27, 7'd19, 7'd11, 7'd3,
    7'd60, 7'd52, 7'd44, 7'd36, 7'd63, 7'd55, 7'd47, 7'd39,
    7'd31, 7'd23, 7'd15, 7'd7,  7'd62, 7'd54, 7'd46, 7'd38,
    7'd30, 7'd22, 7'd14, 7'd6,  7'd61, 7'd53, 7'd45, 7'd37,
    7'd29, 7'd21, 7'd13, 7'd5,  7'd28, 7'd20, 7'd12, 7'd4
  };

  localparam logic [6:0] PC2_TAB [SUBKEY_W] = '{
    7'd14, 7'd17, 7'd11, 7'd24, 7'd1,  7'd5,  7'd3,  7'd28,
    7'd15, 7'd6,  7'd21, 7'd10, 7'd23, 7'd19, 7'd12, 7'd4,
    7'd26, 7'd8,  7'd16, 7'd7,  7'd27, 7'd20, 7'd13, 7'd2,
    7'd41, 7'd52, 7'd31, 7'd37, 7'd47, 7'd55, 7'd30, 7'd40,
    7'd51, 7'd45, 7'd33, 7'd48, 7'd44, 7'd49, 7'd39, 7'd56,
    7'd34, 7'd53, 7'd46, 7'd42, 7'd50, 7'd36, 7'd29, 7'd32
  };

  // source bit (1-based from MSB) of initial-permutation output position i
  function automatic int ipSource(input int i);
    int row, col;
    row = i / 8;
    col = i % 8;
    if (row < 4) return 58 + 2 * row - 8 * col;
    else         return 57 + 2 * (row - 4) - 8 * col;
  endfunction

  function automatic logic [BLOCK_W-1:0] initPerm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] y;
    for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-1-i] = x[BLOCK_W-ipSource(i)];
    return y;
  endfunction

  function automatic logic [BLOCK_W-1:0] finalPerm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] y;
    for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-ipSource(i)] = x[BLOCK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expandHalf(input logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] y;
    for (int j = 0; j < SUBKEY_W; j++) begin
      int src;
      src = ((4 * (j / 6) + (j % 6) + HALF_W - 1) % HALF_W) + 1;
      y[SUBKEY_W-1-j] = r[HALF_W-src];
    end
    return y;
  endfunction

  function automatic logic [3:0] sboxLookup(input int box, input logic [5:0] six);
    int n;
    n = 16 * int'({six[5], six[0]}) + int'(six[4:1]);
    return SBOX_TAB[box][255-4*n -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] roundPerm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int j = 0; j < HALF_W; j++) y[HALF_W-1-j] = x[HALF_W-int'(P_TAB[j])];
    return y;
  endfunction

  // 56-bit key -> 64-bit form with zero parity bits -> choice 1
  function automatic logic [KEY_W-1:0] keyChoice1(input logic [KEY_W-1:0] k);
    logic [BLOCK_W-1:0] wide;
    logic [KEY_W-1:0]   y;
    wide = '0;
    for (int b = 0; b < 8; b++) wide[BLOCK_W-1-8*b -: 7] = k[KEY_W-1-7*b -: 7];
    for (int j = 0; j < KEY_W; j++) y[KEY_W-1-j] = wide[BLOCK_W-int'(PC1_TAB[j])];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] keyChoice2(input logic [KEY_W-1:0] cd);
    logic [SUBKEY_W-1:0] y;
    for (int j = 0; j < SUBKEY_W; j++) y[SUBKEY_W-1-j] = cd[KEY_W-int'(PC2_TAB[j])];
    return y;
  endfunction

  function automatic logic singleShift(input logic [RIDX_W-1:0] idx);
    return (idx == 0) || (idx == 1) || (idx == 8) || (idx == RIDX_W'(ROUNDS - 1));
  endfunction

endpackage

// File: rtl/des_round.sv
`timescale 1ns/1ps
module des_round
  import des_pkg::*;
(
  input  logic [HALF_W-1:0] lIn,
  input  logic [HALF_W-1:0] rIn,
  input  logic [KEY_W-1:0]  cdIn,
  input  logic [RIDX_W-1:0] roundIdx,
  output logic [HALF_W-1:0] lOut,
  output logic [HALF_W-1:0] rOut,
  output logic [KEY_W-1:0]  cdOut
);
  localparam int CD_W = KEY_W / 2;

  logic [CD_W-1:0]     cHalf, dHalf, cNext, dNext;
  logic [SUBKEY_W-1:0] subKey, mixed;
  logic [HALF_W-1:0]   sOut, fOut;

  assign cHalf = cdIn[KEY_W-1:CD_W];
  assign dHalf = cdIn[CD_W-1:0];

  always_comb begin
    if (singleShift(roundIdx)) begin
      cNext = {cHalf[CD_W-2:0], cHalf[CD_W-1]};
      dNext = {dHalf[CD_W-2:0], dHalf[CD_W-1]};
    end else begin
      cNext = {cHalf[CD_W-3:0], cHalf[CD_W-1 -: 2]};
      dNext = {dHalf[CD_W-3:0], dHalf[CD_W-1 -: 2]};
    end
  end

  assign cdOut  = {cNext, dNext};
  assign subKey = keyChoice2(cdOut);
  assign mixed  = expandHalf(rIn) ^ subKey;

  for (genvar g = 0; g < NUM_SBOX; g++) begin : gSbox
    assign sOut[HALF_W-1-4*g -: 4] = sboxLookup(g, mixed[SUBKEY_W-1-6*g -: 6]);
  end

  assign fOut = roundPerm(sOut);
  assign lOut = rIn;
  assign rOut = lIn ^ fOut;
endmodule

// File: rtl/des_datapath.sv
`timescale 1ns/1ps
module des_datapath
  import des_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [RIDX_W-1:0]  roundIdx,
  input  logic [BLOCK_W-1:0] plainIn,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic               scanIn,
  output logic [BLOCK_W-1:0] cipherOut,
  output logic               scanOut
);
  logic [BLOCK_W-1:0] inReg, outReg;
  logic [HALF_W-1:0]  lReg, rReg, lNext, rNext;
  logic [KEY_W-1:0]   cdReg, cdNext;
  logic [CHAIN_W-1:0] chainNow, chainShifted;

  des_round u_round (
    .lIn      (lReg),
    .rIn      (rReg),
    .cdIn     (cdReg),
    .roundIdx (roundIdx),
    .lOut     (lNext),
    .rOut     (rNext),
    .cdOut    (cdNext)
  );

  assign chainNow     = {inReg, lReg, rReg, outReg};
  assign chainShifted = {scanIn, chainNow[CHAIN_W-1:1]};

  // scannable data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      lReg   <= '0;
      rReg   <= '0;
      outReg <= '0;
    end else if (strobe.scanShift) begin
      {inReg, lReg, rReg, outReg} <= chainShifted;
    end else begin
      if (strobe.loadIn)    inReg <= plainIn ^ outReg;
      if (strobe.loadLR)    {lReg, rReg} <= initPerm(inReg);
      if (strobe.doRound) begin
        lReg <= lNext;
        rReg <= rNext;
      end
      if (strobe.lastRound) outReg <= finalPerm({rNext, lNext});
    end
  end

  // key-schedule register, outside the scan chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  cdReg <= '0;
    else if (!strobe.scanShift && strobe.loadIn) cdReg <= keyChoice1(keyIn);
    else if (!strobe.scanShift && strobe.doRound) cdReg <= cdNext;
  end

  assign cipherOut = outReg;
  assign scanOut   = chainNow[0];
endmodule

// File: rtl/des_control.sv
`timescale 1ns/1ps
module des_control
  import des_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              scanEn,
  output ctrlStrobe_t       strobe,
  output logic [RIDX_W-1:0] roundIdx,
  output logic              done,
  output logic              busy
);
  ctrlState_e        state;
  logic [RIDX_W-1:0] roundCnt;
  logic              doneReg;
  logic              lastCnt;

  assign lastCnt = (roundCnt == RIDX_W'(ROUNDS - 1));

  always_comb begin
    strobe.scanShift = scanEn;
    strobe.loadIn    = !scanEn && (state == ST_IDLE) && start;
    strobe.loadLR    = !scanEn && (state == ST_PREP);
    strobe.doRound   = !scanEn && (state == ST_RUN);
    strobe.lastRound = !scanEn && (state == ST_RUN) && lastCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      roundCnt <= '0;
      doneReg  <= 1'b0;
    end else if (scanEn) begin
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) state <= ST_PREP;
        ST_PREP: begin
          state    <= ST_RUN;
          roundCnt <= '0;
        end
        ST_RUN: begin
          roundCnt <= roundCnt + 1'b1;
          if (lastCnt) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign roundIdx = roundCnt;
  assign done     = doneReg;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/des_cbc_scan.sv
`timescale 1ns/1ps
module des_cbc_scan
  import des_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BLOCK_W-1:0] plainIn,
  input  logic [KEY_W-1:0]   keyIn,
  output logic [BLOCK_W-1:0] cipherOut,
  output logic               done,
  input  logic               scanEn,
  input  logic               scanIn,
  output logic               scanOut
);
  ctrlStrobe_t       strobe;
  logic [RIDX_W-1:0] roundIdx;
  logic              busyInt;

  des_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .scanEn   (scanEn),
    .strobe   (strobe),
    .roundIdx (roundIdx),
    .done     (done),
    .busy     (busyInt)
  );

  des_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .roundIdx  (roundIdx),
    .plainIn   (plainIn),
    .keyIn     (keyIn),
    .scanIn    (scanIn),
    .cipherOut (cipherOut),
    .scanOut   (scanOut)
  );
endmodule

// File: rtl/des_cbc_scan_checker.sv
`timescale 1ns/1ps
module des_cbc_scan_checker
  import des_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               scanEn,
  input logic               done,
  input logic               busy,
  input logic [BLOCK_W-1:0] cipherOut
);
  localparam int LAT   = ROUNDS + 2;
  localparam int LAT_W = $clog2(LAT + 1);

  logic [LAT_W-1:0] normalEdges;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) normalEdges <= '0;
    else if (!scanEn) begin
      if (start && !busy)                                  normalEdges <= LAT_W'(1);
      else if (normalEdges != 0 && normalEdges != LAT_W'(LAT)) normalEdges <= normalEdges + 1'b1;
      else                                                 normalEdges <= '0;
    end
  end

  // R1: outputs cleared on reset release
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cipherOut == '0) && !done);

  // R4: completion lands on the 18th functional edge
  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (normalEdges == LAT_W'(LAT)));

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: no completion from a scan edge
  a_r7_scan_no_done: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> !done);

  // R6: ciphertext register moves toward the tail by one place per scan edge
  a_r6_shift_out: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> (cipherOut[BLOCK_W-2:0] == $past(cipherOut[BLOCK_W-1:1])));

  // R8: ciphertext register only changes on completion or scan
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> (cipherOut == $past(cipherOut)) || done);
endmodule

bind des_cbc_scan des_cbc_scan_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .scanEn    (scanEn),
  .done      (done),
  .busy      (busyInt),
  .cipherOut (cipherOut)
);

// File: tb/des_cbc_scan_tb.sv
`timescale 1ns/1ps
module des_cbc_scan_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] plainIn = '0;
  logic [55:0] keyIn = '0;
  logic [63:0] cipherOut;
  logic        done;
  logic        scanEn = 1'b0;
  logic        scanIn = 1'b0;
  logic        scanOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [63:0] expQ [$];

  localparam logic [63:0] K_A = 64'h133457799BBCDFF1;
  localparam logic [63:0] K_B = 64'h0E329232EA6D0D73;
  localparam logic [63:0] K_Z = 64'h0;
  localparam logic [63:0] K_F = 64'hFFFFFFFFFFFFFFFF;
  localparam logic [63:0] PT_A = 64'h0123456789ABCDEF;
  localparam logic [63:0] CT_A = 64'h85E813540F0AB405;
  localparam logic [63:0] PT_B = 64'h8787878787878787;
  localparam logic [63:0] CT_Z = 64'h8CA64DE9C1B123A7;
  localparam logic [63:0] CT_F = 64'h7359B2163E4EDC58;

  des_cbc_scan u_dut (
    .clk(clk), .rstN(rstN), .start(start), .plainIn(plainIn), .keyIn(keyIn),
    .cipherOut(cipherOut), .done(done), .scanEn(scanEn), .scanIn(scanIn), .scanOut(scanOut)
  );

  always #10 clk = ~clk;

  function automatic logic [55:0] dropParity(input logic [63:0] k);
    logic [55:0] r;
    for (int b = 0; b < 8; b++) r[55-7*b -: 7] = k[63-8*b -: 7];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: scoreboard pops on every completion pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(0, "R5 unexpected done", 192'(cipherOut), 192'h0);
      else begin
        logic [63:0] e;
        e = expQ.pop_front();
        check(cipherOut == e, "R2/R3 ciphertext", 192'(cipherOut), 192'(e));
      end
    end
  end

  // driver: one block, with latency check and optional start poke while busy
  task automatic runBlock(input logic [63:0] pt, input logic [63:0] key, input logic [63:0] exp,
                          input bit pokeBusy);
    int k;
    expQ.push_back(exp);
    plainIn = pt;
    keyIn   = dropParity(key);
    start   = 1'b1;
    for (k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (pokeBusy && k == 5) begin start = 1'b1; plainIn = ~pt; keyIn = '1; end
      if (pokeBusy && k == 6) start = 1'b0;
      if (done) break;
    end
    check(k == 18, "R4 done latency", 192'(k), 192'(18));
    @(negedge clk);
    check(!done, "R4 done single pulse", 192'(done), 192'h0);
  endtask

  task automatic scanLoop(output logic [191:0] cap);
    scanEn = 1'b1;
    for (int t = 0; t < 192; t++) begin
      cap[t] = scanOut;
      scanIn = scanOut;
      @(negedge clk);
    end
    scanEn = 1'b0;
  endtask

  task automatic scanLoad(input logic [191:0] v);
    scanEn = 1'b1;
    for (int t = 0; t < 192; t++) begin
      scanIn = v[t];
      @(negedge clk);
    end
    scanEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 192'h0, 192'h1);
    finish_run();
  end

  initial begin
    logic [191:0] cap;
    logic [191:0] pat;
    logic [63:0]  hold;
    int normal;
    bit sawDone;

    @(negedge clk);
    doReset();
    // R1 reset state
    check(cipherOut == 0, "R1 cipherOut after reset", 192'(cipherOut), 192'h0);
    check(!done, "R1 done after reset", 192'(done), 192'h0);
    check(scanOut == 0, "R1 scanOut after reset", 192'(scanOut), 192'h0);

    // R2 known answers, chained per R3 so each block reduces to single-block DES
    runBlock(PT_A, K_A, CT_A, 0);                       // R2
    runBlock(PT_B ^ CT_A, K_B, 64'h0, 0);               // R3 chaining
    runBlock(64'h0, K_Z, CT_Z, 0);                      // R2
    runBlock(K_F ^ CT_Z, K_F, CT_F, 0);                 // R3
    // R5 start poked mid-run is ignored
    runBlock(PT_B ^ CT_F, K_B, 64'h0, 1);

    // R4/R6/R7: observe round registers via scan in the middle of a run
    doReset();
    expQ.push_back(CT_A);
    plainIn = PT_A;
    keyIn   = dropParity(K_A);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    normal = 2;
    scanLoop(cap);
    check(cap[191:128] == PT_A, "R3 block input with zero IV", 192'(cap[191:128]), 192'(PT_A));
    check(cap[127:96] == 32'hCC00CCFF, "R4 left half after IP", 192'(cap[127:96]), 192'h CC00CCFF);
    check(cap[95:64] == 32'hF0AAF0AA, "R4 right half after IP", 192'(cap[95:64]), 192'hF0AAF0AA);
    check(cap[63:0] == 64'h0, "R6 ciphertext bits lead the chain", 192'(cap[63:0]), 192'h0);
    check(cipherOut == 64'h0, "R8 loopback keeps cipherOut", 192'(cipherOut), 192'h0);
    @(negedge clk);
    normal++;
    scanLoop(cap);
    check(cap[127:96] == 32'hF0AAF0AA, "R4 left half after round 1", 192'(cap[127:96]), 192'hF0AAF0AA);
    check(cap[95:64] == 32'hEF4A6544, "R4 right half after round 1", 192'(cap[95:64]), 192'hEF4A6544);
    while (!done && normal < 40) begin
      @(negedge clk);
      normal++;
    end
    check(normal == 18, "R7 functional edges unchanged by scan", 192'(normal), 192'(18));
    @(negedge clk);

    // R5 start during scan is ignored; R6 ciphertext order at scanOut
    plainIn = 64'hDEADBEEFCAFEF00D;
    start   = 1'b1;
    scanLoop(cap);
    start = 1'b0;
    check(cap[63:0] == CT_A, "R6 ciphertext LSB first at scanOut", 192'(cap[63:0]), 192'(CT_A));
    check(cipherOut == CT_A, "R8 loopback restores cipherOut", 192'(cipherOut), 192'(CT_A));
    sawDone = 0;
    repeat (25) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    check(!sawDone, "R5 no run started by start under scan", 192'(sawDone), 192'h0);
    check(cipherOut == CT_A, "R5 cipherOut untouched", 192'(cipherOut), 192'(CT_A));

    // R6 load a pattern, R8 read it back intact
    pat = {64'hA5A5_5A5A_0FF0_F00F, 32'h1357_9BDF, 32'h2468_ACE0, 64'h0F1E_2D3C_4B5A_6978};
    scanLoad(pat);
    check(cipherOut == pat[63:0], "R6 scanned value lands in ciphertext register", 192'(cipherOut), 192'(pat[63:0]));
    scanLoop(cap);
    check(cap == pat, "R8 full chain readback", cap, pat);
    check(cipherOut == pat[63:0], "R8 chain intact after loopback", 192'(cipherOut), 192'(pat[63:0]));
    hold = pat[63:0];
    // R3 scanned ciphertext acts as chaining value
    runBlock(PT_A ^ hold, K_A, CT_A, 0);

    // R1 reset abandons a run
    plainIn = PT_B;
    keyIn   = dropParity(K_B);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(cipherOut == 0 && !done, "R1 reset mid-run clears", 192'(cipherOut), 192'h0);
    rstN = 1'b1;
    sawDone = 0;
    repeat (25) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    check(!sawDone, "R1 abandoned run never completes", 192'(sawDone), 192'h0);
    runBlock(PT_A, K_A, CT_A, 0);                       // R1 zero chain after reset

    check(expQ.size() == 0, "R4 every block completed", 192'(expQ.size()), 192'h0);
    finish_run();
  end
endmodule